// File: doc/BRIEF.md
# Vector Register-Group Element Sequencer

This block takes one decoded vector arithmetic instruction and walks it over a datapath whose registers are 128 bits wide. The instruction arrives with three register numbers (destination and two sources), an element-width code, a group-size code and an active vector length. The block splits the register group into one pass per physical register. It presents the source registers at the start of each pass and the destination register at the end of it. With each write it also gives per-element write enables, which follow the vector length and the tail policy.

The arithmetic is not part of this block. Each pass holds the datapath for a fixed number of cycles, so an instruction always takes a time set only by its group size, even when its vector length is zero. Register numbers that are not multiples of the group size are refused when the instruction is offered. Such an instruction never starts and reports a one-cycle fault.

Top module: `vgrp_seq`

## Requirements
- R1: `in_ready_o` is high exactly when the block is idle. An instruction is taken on a rising edge where `in_valid_i` and `in_ready_o` are both high. A request raised while busy does not change the instruction in flight.
- R2: A legal instruction keeps `busy_o` high for exactly PASS_CYC (default 3) times the group size in cycles, counted from the cycle after the accept edge. This holds for every vector length, including zero.
- R3: `done_o` is a single-cycle pulse in the first cycle after the last busy cycle. In that cycle `busy_o` is low.
- R4: `vd_i`, `vs1_i` and `vs2_i` must all be multiples of the group size. If any of them is not, `fault_o` pulses in the cycle after the accept edge, `busy_o` stays low, and no read or write strobe appears.
- R5: Passes run in ascending order. In pass p, `rd_valid_o` is high in the first cycle of the pass, with `rd_vs1_o`/`rd_vs2_o` equal to the source base plus p. `wr_valid_o` is high in the last cycle of the pass, with `wr_reg_o` equal to the destination base plus p.
- R6: Element-width code 0/1/2/3 means 8/16/32/64-bit elements, giving 16/8/4/2 elements per register. `wr_en_o` bit j belongs to element j of the register, and bits at or above the element count are always zero.
- R7: With `tail_agn_i` low (tail undisturbed), element j of pass p is enabled exactly when its group index p*E+j is below `vl_i`, where E is the number of elements per register.
- R8: With `tail_agn_i` high (tail agnostic), element j of pass p is enabled exactly when `vl_i` is nonzero and (p*E+j)/4 is at most (`vl_i`-1)/4. Lane blocks are 4 elements wide, so later blocks are skipped.
- R9: Group-size code 0/1/2/3 means 1/2/4/8 registers.
- R10: After reset the block is idle, with `in_ready_o` high and every strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Block can take an instruction |
| vd_i | input | 5 | Destination base register |
| vs1_i | input | 5 | First source base register |
| vs2_i | input | 5 | Second source base register |
| sew_i | input | 2 | Element-width code |
| grp_i | input | 2 | Group-size code |
| vl_i | input | 8 | Active vector length in elements |
| tail_agn_i | input | 1 | 1 = tail agnostic, 0 = tail undisturbed |
| busy_o | output | 1 | Instruction in flight |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Misaligned register pulse |
| rd_valid_o | output | 1 | Source read strobe, first cycle of each pass |
| rd_vs1_o | output | 5 | First source register of the pass |
| rd_vs2_o | output | 5 | Second source register of the pass |
| wr_valid_o | output | 1 | Write strobe, last cycle of each pass |
| wr_reg_o | output | 5 | Destination register of the pass |
| wr_en_o | output | 16 | Per-element write enables |

## Verification
Cycle c is counted from 0 at the first edge after the accept edge. Under that count:
- `busy_o` is high for cycles 0 to 3L-1, where L is the group size.
- A read strobe is due at every c with c mod 3 = 0, and a write strobe with its enables at every c with c mod 3 = 2, both for register base + c/3.
- `done_o` is due at c = 3L. A fault is due at c = 0, in place of the whole sequence.

The bench drives inputs on falling edges and samples every output on the falling edge after each rising edge. Each sample is compared with the value its model predicts for that exact c, so an output that is one cycle early or late fails its check.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  localparam int unsigned VLEN_BITS = 128;
  localparam int unsigned NUM_VREGS = 32;
  localparam int unsigned MAX_ELEMS = VLEN_BITS / 8;
  localparam int unsigned VL_W      = $clog2(MAX_ELEMS * 8 + 1);
  localparam int unsigned REG_W     = $clog2(NUM_VREGS);

  typedef enum logic [1:0] {SEW_8, SEW_16, SEW_32, SEW_64} sew_e;
  typedef enum logic [1:0] {GRP_1, GRP_2, GRP_4, GRP_8} grp_e;

  typedef struct packed {
    logic [REG_W-1:0] vd;
    logic [REG_W-1:0] vs1;
    logic [REG_W-1:0] vs2;
    sew_e             sew;
    grp_e             grp;
    logic [VL_W-1:0]  vl;
    logic             tail_agn;
  } vinstr_t;

  function automatic logic [3:0] grp_regs(grp_e g);
    return 4'd1 << g;
  endfunction
endpackage

// File: rtl/vgs_align_chk.sv
module vgs_align_chk
  import vgs_pkg::*;
(
  input  grp_e             grp_i,
  input  logic [REG_W-1:0] vd_i,
  input  logic [REG_W-1:0] vs1_i,
  input  logic [REG_W-1:0] vs2_i,
  output logic             legal_o
);
  localparam int unsigned NFIELDS = 3;

  logic [REG_W-1:0] low_mask;
  logic [REG_W-1:0] fields [NFIELDS];
  logic [NFIELDS-1:0] ok;

  assign low_mask  = REG_W'(grp_regs(grp_i) - 4'd1);
  assign fields[0] = vd_i;
  assign fields[1] = vs1_i;
  assign fields[2] = vs2_i;

  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    assign ok[f] = (fields[f] & low_mask) == '0;
  end

  assign legal_o = &ok;
endmodule

// File: rtl/vgs_lane_mask.sv
module vgs_lane_mask
  import vgs_pkg::*;
#(
  parameter int unsigned BLK_LANES = 4
) (
  input  logic [2:0]           pass_i,
  input  sew_e                 sew_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic                 tail_agn_i,
  output logic [MAX_ELEMS-1:0] en_o
);
  localparam int unsigned ELEM_SH = $clog2(MAX_ELEMS);
  localparam int unsigned BLK_SH  = $clog2(BLK_LANES);
  localparam int unsigned IDX_W   = VL_W + 1;

  logic [IDX_W-1:0] vl_x;
  logic [IDX_W-1:0] last_blk;
  logic             vl_zero;
  logic [IDX_W-1:0] elems;

  assign vl_x     = IDX_W'(vl_i);
  assign vl_zero  = (vl_i == '0);
  assign last_blk = (vl_x - IDX_W'(1)) >> BLK_SH;
  assign elems    = IDX_W'(MAX_ELEMS) >> sew_i;

  for (genvar j = 0; j < MAX_ELEMS; j++) begin : g_elem
    logic [IDX_W-1:0] gidx;
    logic             in_reg, hit_ud, hit_ta;
    assign gidx   = (IDX_W'(pass_i) << (ELEM_SH - 32'(sew_i))) + IDX_W'(j);
    assign in_reg = IDX_W'(j) < elems;
    assign hit_ud = gidx < vl_x;
    // whole lane block holding the last active element may be written
    assign hit_ta = !vl_zero && ((gidx >> BLK_SH) <= last_blk);
    assign en_o[j] = in_reg & (tail_agn_i ? hit_ta : hit_ud);
  end
endmodule

// File: rtl/vgs_seq_ctrl.sv
module vgs_seq_ctrl
  import vgs_pkg::*;
#(
  parameter int unsigned PASS_CYC = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    in_valid_i,
  input  logic    legal_i,
  input  vinstr_t instr_i,
  output logic    in_ready_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    fault_o,
  output logic [2:0] pass_o,
  output logic    first_o,
  output logic    last_o,
  output vinstr_t instr_o
);
  localparam int unsigned CYC_W = (PASS_CYC > 1) ? $clog2(PASS_CYC) : 1;

  logic             busy_q, done_q, fault_q;
  logic [CYC_W-1:0] cyc_q;
  logic [2:0]       pass_q;
  vinstr_t          instr_q;
  logic             accept, cyc_end, pass_end;

  assign accept   = in_valid_i & ~busy_q;
  assign cyc_end  = cyc_q == CYC_W'(PASS_CYC - 1);
  assign pass_end = pass_q == 3'(grp_regs(instr_q.grp) - 4'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cyc_q   <= '0;
      pass_q  <= '0;
      instr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (accept) begin
        if (legal_i) begin
          busy_q  <= 1'b1;
          cyc_q   <= '0;
          pass_q  <= '0;
          instr_q <= instr_i;
        end else begin
          fault_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (cyc_end) begin
          cyc_q <= '0;
          if (pass_end) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            pass_q <= pass_q + 3'd1;
          end
        end else begin
          cyc_q <= cyc_q + CYC_W'(1);
        end
      end
    end
  end

  assign in_ready_o = ~busy_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign pass_o     = pass_q;
  assign first_o    = busy_q && (cyc_q == '0);
  assign last_o     = busy_q && cyc_end;
  assign instr_o    = instr_q;

  // R3
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R4
  fault_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!busy_o && !done_o));
  // R5
  pass_ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (pass_o == $past(pass_o) || pass_o == $past(pass_o) + 3'd1));
  // R9
  pass_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (4'(pass_o) < grp_regs(instr_o.grp)));
endmodule

// File: rtl/vgrp_seq.sv
module vgrp_seq
  import vgs_pkg::*;
#(
  parameter int unsigned PASS_CYC  = 3,
  parameter int unsigned BLK_LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [REG_W-1:0]     vd_i,
  input  logic [REG_W-1:0]     vs1_i,
  input  logic [REG_W-1:0]     vs2_i,
  input  logic [1:0]           sew_i,
  input  logic [1:0]           grp_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic                 tail_agn_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 fault_o,
  output logic                 rd_valid_o,
  output logic [REG_W-1:0]     rd_vs1_o,
  output logic [REG_W-1:0]     rd_vs2_o,
  output logic                 wr_valid_o,
  output logic [REG_W-1:0]     wr_reg_o,
  output logic [MAX_ELEMS-1:0] wr_en_o
);
  vinstr_t              in_instr, cur;
  logic                 legal, first, last;
  logic [2:0]           pass;
  logic [MAX_ELEMS-1:0] lane_en;

  assign in_instr = '{vd: vd_i, vs1: vs1_i, vs2: vs2_i, sew: sew_e'(sew_i),
                      grp: grp_e'(grp_i), vl: vl_i, tail_agn: tail_agn_i};

  vgs_align_chk u_align (
    .grp_i   (grp_e'(grp_i)),
    .vd_i    (vd_i),
    .vs1_i   (vs1_i),
    .vs2_i   (vs2_i),
    .legal_o (legal)
  );

  vgs_seq_ctrl #(.PASS_CYC(PASS_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .legal_i    (legal),
    .instr_i    (in_instr),
    .in_ready_o (in_ready_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .pass_o     (pass),
    .first_o    (first),
    .last_o     (last),
    .instr_o    (cur)
  );

  vgs_lane_mask #(.BLK_LANES(BLK_LANES)) u_mask (
    .pass_i     (pass),
    .sew_i      (cur.sew),
    .vl_i       (cur.vl),
    .tail_agn_i (cur.tail_agn),
    .en_o       (lane_en)
  );

  assign rd_valid_o = first;
  assign rd_vs1_o   = cur.vs1 + REG_W'(pass);
  assign rd_vs2_o   = cur.vs2 + REG_W'(pass);
  assign wr_valid_o = last;
  assign wr_reg_o   = cur.vd + REG_W'(pass);
  assign wr_en_o    = last ? lane_en : '0;

  // R6
  elem_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($countones(wr_en_o) <= (MAX_ELEMS >> cur.sew)));
  // R7
  undisturbed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !cur.tail_agn && cur.vl == '0) |-> (wr_en_o == '0));
  // R4
  no_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o || rd_valid_o) |-> busy_o);
  // R1
  hold_instr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cur));
endmodule

// File: tb/vgrp_seq_bench.sv
module vgrp_seq_bench;
  localparam int PC = 3;
  localparam int NE = 16;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] vd = '0, vs1 = '0, vs2 = '0;
  logic [1:0] sew = '0, grp = '0;
  logic [7:0] vl = '0;
  logic ta = 1'b0;
  logic in_ready, busy, done, fault, rd_valid, wr_valid;
  logic [4:0] rd_vs1, rd_vs2, wr_reg;
  logic [15:0] wr_en;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vgrp_seq u_vgrp_seq (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .vd_i(vd), .vs1_i(vs1), .vs2_i(vs2), .sew_i(sew), .grp_i(grp), .vl_i(vl),
    .tail_agn_i(ta), .busy_o(busy), .done_o(done), .fault_o(fault),
    .rd_valid_o(rd_valid), .rd_vs1_o(rd_vs1), .rd_vs2_o(rd_vs2),
    .wr_valid_o(wr_valid), .wr_reg_o(wr_reg), .wr_en_o(wr_en)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_en(int p, int s, int len, bit agn);
    logic [15:0] m = '0;
    int e = NE >> s;
    for (int j = 0; j < e; j++) begin
      int g = p * e + j;
      if (agn) m[j] = (len > 0) && (g / BL <= (len - 1) / BL);
      else     m[j] = g < len;
    end
    return m;
  endfunction

  // status vector: busy ready done fault rd_valid wr_valid
  function automatic logic [5:0] stat();
    return {busy, in_ready, done, fault, rd_valid, wr_valid};
  endfunction

  task automatic run(int d, int a, int b, int s, int gc, int len, bit agn, bit poke);
    int L = 1 << gc;
    bit legal = (d % L == 0) && (a % L == 0) && (b % L == 0);
    string tg = agn ? "R8" : "R7";
    @(negedge clk);
    vd = 5'(d); vs1 = 5'(a); vs2 = 5'(b); sew = 2'(s); grp = 2'(gc);
    vl = 8'(len); ta = agn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (!legal) begin
      chk(stat() == 6'b010100, "R4 fault", stat(), 6'b010100);
      @(negedge clk);
      chk(stat() == 6'b010000, "R4 after fault", stat(), 6'b010000);
      return;
    end
    for (int c = 0; c < PC * L; c++) begin
      logic [5:0 ] es;
      int p = c / PC;
      es = {1'b1, 1'b0, 1'b0, 1'b0, (c % PC) == 0, (c % PC) == PC - 1};
      chk(stat() == es, "R2 R5 R9 busy", stat(), es);
      if (rd_valid) begin
        chk(rd_vs1 == 5'(a + p) && rd_vs2 == 5'(b + p), "R5 rd regs",
            {rd_vs1, rd_vs2}, (a + p) * 32 + (b + p));
      end
      if (wr_valid) begin
        logic [15:0] em = exp_en(p, s, len, agn);
        chk(wr_reg == 5'(d + p), "R5 wr reg", wr_reg, d + p);
        chk(wr_en == em, {tg, " R6 en"}, wr_en, em);
      end
      if (poke && c == 1) begin
        vd = 5'(d + L); vs1 = 5'(a + L); in_valid = 1'b1;
      end
      if (poke && c == 2) in_valid = 1'b0;
      @(negedge clk);
    end
    chk(stat() == 6'b011000, "R3 done", stat(), 6'b011000);
    @(negedge clk);
    chk(stat() == 6'b010000, "R1 R3 idle", stat(), 6'b010000);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(stat() == 6'b010000, "R10 in reset", stat(), 6'b010000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat() == 6'b010000, "R10 after reset", stat(), 6'b010000);
    // directed corners
    run(0, 8, 16, 0, 0, 0, 0, 0);      // R2 R7 zero length
    run(0, 8, 16, 0, 0, 0, 1, 0);      // R8 zero length
    run(8, 16, 24, 0, 3, 128, 0, 0);   // R9 full group
    run(24, 0, 8, 2, 3, 5, 1, 0);      // R8 one block in pass 1
    run(24, 0, 8, 2, 3, 5, 0, 0);      // R7
    run(9, 0, 8, 0, 3, 10, 0, 0);      // R4 vd misaligned
    run(8, 0, 6, 1, 2, 10, 0, 0);      // R4 vs2 misaligned
    run(0, 3, 4, 1, 1, 3, 0, 0);       // R4 vs1 misaligned
    run(4, 8, 12, 3, 2, 3, 1, 1);      // R1 request while busy
    run(2, 4, 6, 1, 1, 9, 1, 0);       // R8 block across registers
    for (int i = 0; i < 150; i++) begin
      int gc = $urandom % 4;
      int L = 1 << gc;
      int s = $urandom % 4;
      int vmax = (L * NE) >> s;
      int len = $urandom % (vmax + 1);
      int d = ($urandom % 32) & ~(L - 1);
      int a = ($urandom % 32) & ~(L - 1);
      int b = ($urandom % 32) & ~(L - 1);
      if (L > 1 && ($urandom % 6) == 0) begin
        case ($urandom % 3)
          0: d = d + 1;
          1: a = a + L - 1;
          default: b = b + 1;
        endcase
      end
      run(d, a, b, s, gc, len, 1'($urandom % 2), 1'($urandom % 8 == 0));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule